// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit data pin of a single-wire automotive bus transceiver and the enable of its low-side driver. A low level on transmit data asks for a dominant bus. A high level, including a pin left open and pulled up, leaves the bus recessive. The guard passes these requests through while the transceiver is in normal mode. It stops a stuck microcontroller or a transmit pin shorted to ground from holding the bus dominant forever.

A dominant request that lasts `DOM_LIMIT` consecutive samples trips a timeout. The timeout forces the driver recessive and raises a status flag. Mode-control logic outside this block may use that flag to accept a sleep request while transmit data is still low. The driver is released only after transmit data has been high for `HIGH_MIN` consecutive samples. The same lockout applies when normal mode is entered while transmit data is already low. Leaving normal mode clears everything and keeps the driver recessive.

Top module: `tx_dom_guard`

## Requirements
- R1: While `normal_i` is 0, both `drive_dom_o` and `timeout_o` read 0 one cycle later, and any pending lockout or timeout is dropped.
- R2: In normal mode with no lockout, `drive_dom_o` follows the inverse of `txd_i` with one cycle of latency (txd 0 gives 1, txd 1 gives 0).
- R3: The `DOM_LIMIT`-th consecutive low sample of `txd_i` in normal mode trips a timeout: `drive_dom_o` goes to 0 and `timeout_o` goes to 1 in the cycle after that sample. So the driver is never dominant for more than `DOM_LIMIT`-1 consecutive cycles.
- R4: During a lockout, `drive_dom_o` stays 0 whatever `txd_i` does. After a timeout, `timeout_o` stays 1 for as long as the lockout lasts.
- R5: A lockout ends on the `HIGH_MIN`-th consecutive high sample of `txd_i`. From the cycle after that sample, `timeout_o` reads 0, and a following low sample drives dominant again.
- R6: Any low sample during a lockout restarts the high-time count from zero.
- R7: If `txd_i` is low in the first normal-mode sample after a non-normal cycle, a lockout starts without setting `timeout_o`, and R5 governs its release.
- R8: Asynchronous active-low reset `rst_n` forces both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Transmit data, 0 requests dominant |
| normal_i | input | 1 | 1 while the transceiver is in normal mode |
| drive_dom_o | output | 1 | 1 turns the bus driver on (dominant) |
| timeout_o | output | 1 | 1 while locked out after a dominant timeout |

## Verification
The assertions assume that `txd_i` and `normal_i` are synchronous to `clk` and settle between edges. They also assume that the inverted-transmit relation applies only while no lockout is pending. The bench changes inputs only on the falling edge and reads the outputs one falling edge after the rising edge that sampled them. It uses small limits (20 and 5) so that every timeout, restart and release boundary is reached in a few dozen cycles.

// File: rtl/tx_dom_guard.sv
module tx_dom_guard #(
  parameter int DOM_LIMIT = 40000,
  parameter int HIGH_MIN  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_i,
  input  logic normal_i,
  output logic drive_dom_o,
  output logic timeout_o
);
  localparam int DW = $clog2(DOM_LIMIT + 1);
  localparam int HW = $clog2(HIGH_MIN + 1);

  logic [DW-1:0] dom_cnt;
  logic [HW-1:0] hi_cnt;
  logic          lock, norm_q;

  wire entry_low = ~norm_q & ~txd_i;
  wire lock_cur  = lock | entry_low;
  wire release_w = lock & txd_i & (hi_cnt == HW'(HIGH_MIN - 1));
  wire trip      = ~lock_cur & ~txd_i & (dom_cnt == DW'(DOM_LIMIT - 1));
  wire lock_n    = (lock_cur & ~release_w) | trip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_cnt     <= '0;
      hi_cnt      <= '0;
      lock        <= 1'b0;
      norm_q      <= 1'b0;
      drive_dom_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else if (!normal_i) begin
      dom_cnt     <= '0;
      hi_cnt      <= '0;
      lock        <= 1'b0;
      norm_q      <= 1'b0;
      drive_dom_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      norm_q      <= 1'b1;
      lock        <= lock_n;
      dom_cnt     <= (~lock_n & ~txd_i) ? dom_cnt + 1'b1 : '0;
      hi_cnt      <= (lock & ~release_w & txd_i) ? hi_cnt + 1'b1 : '0;
      drive_dom_o <= ~txd_i & ~lock_n;
      timeout_o   <= trip | (timeout_o & lock_n);
    end
  end
endmodule

// File: rtl/tx_dom_guard_chk.sv
module tx_dom_guard_chk #(
  parameter int DOM_LIMIT = 40000
) (
  input logic clk,
  input logic rst_n,
  input logic txd_i,
  input logic normal_i,
  input logic drive_dom_o,
  input logic timeout_o
);
  localparam int RW = $clog2(DOM_LIMIT + 1);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else if (drive_dom_o) run <= (run == RW'(DOM_LIMIT)) ? run : run + 1'b1;
    else run <= '0;

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_i |=> (!drive_dom_o && !timeout_o));

  a_r2_high_is_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    txd_i |=> !drive_dom_o);

  a_r2_dom_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    drive_dom_o |-> $past(!txd_i && normal_i));

  a_r4_flag_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> !drive_dom_o);

  a_r3_dom_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    drive_dom_o |-> (run < RW'(DOM_LIMIT - 1)));

  a_r5_flag_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(!txd_i));
endmodule

bind tx_dom_guard tx_dom_guard_chk #(.DOM_LIMIT(DOM_LIMIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .txd_i(txd_i), .normal_i(normal_i),
  .drive_dom_o(drive_dom_o), .timeout_o(timeout_o)
);

// File: tb/tx_dom_guard_tb_top.sv
module tx_dom_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DOM_LIMIT  = 20;
  localparam int HIGH_MIN   = 5;

  // {normal, txd, expected drive, expected timeout}
  localparam logic [3:0] VEC [16] = '{
    4'b0100, 4'b1100, 4'b1010, 4'b1010,
    4'b1100, 4'b1010, 4'b0000, 4'b0100,
    4'b1000, 4'b1000, 4'b1100, 4'b1100,
    4'b1100, 4'b1100, 4'b1100, 4'b1010
  };

  logic clk = 1'b0, rst_n = 1'b0, txd = 1'b1, norm = 1'b0;
  logic drv, tmo;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_dom_guard #(.DOM_LIMIT(DOM_LIMIT), .HIGH_MIN(HIGH_MIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .txd_i(txd), .normal_i(norm),
    .drive_dom_o(drv), .timeout_o(tmo)
  );

  task automatic check(input string req, input logic ed, input logic et);
    checks++;
    if (drv !== ed || tmo !== et) begin
      fails++;
      $display("FAIL %s: drive=%b timeout=%b expected drive=%b timeout=%b", req, drv, tmo, ed, et);
    end
  endtask

  task automatic step(input logic n, input logic t);
    norm = n; txd = t;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      step(VEC[i][3], VEC[i][2]);
      check("R1 R2 R7 vector", VEC[i][1], VEC[i][0]);
    end
    step(1, 1);
    for (int i = 1; i < DOM_LIMIT; i++) begin
      step(1, 0);
      check("R3 dominant before limit", 1'b1, 1'b0);
    end
    step(1, 0);
    check("R3 timeout trips", 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) begin
      step(1, 0);
      check("R4 held low while locked", 1'b0, 1'b1);
    end
    for (int i = 0; i < HIGH_MIN - 1; i++) step(1, 1);
    check("R4 still locked short high", 1'b0, 1'b1);
    step(1, 0);
    check("R6 low restarts count", 1'b0, 1'b1);
    for (int i = 0; i < HIGH_MIN - 1; i++) step(1, 1);
    check("R6 count restarted", 1'b0, 1'b1);
    step(1, 1);
    check("R5 release", 1'b0, 1'b0);
    step(1, 0);
    check("R5 dominant after release", 1'b1, 1'b0);
    for (int i = 1; i < DOM_LIMIT; i++) step(1, 0);
    check("R3 second timeout", 1'b0, 1'b1);
    step(0, 0);
    check("R1 leaving clears flag", 1'b0, 1'b0);
    step(1, 1);
    step(1, 0);
    check("R1 no stale lockout", 1'b1, 1'b0);
    step(0, 0);
    step(1, 0);
    check("R7 entry low locks", 1'b0, 1'b0);
    step(1, 1); step(1, 1);
    step(1, 0);
    check("R7 short high keeps lock", 1'b0, 1'b0);
    for (int i = 0; i < HIGH_MIN; i++) step(1, 1);
    step(1, 0);
    check("R7 release after high time", 1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R8 async reset", 1'b0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: expected=finish actual=hang");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule